// File: doc/BRIEF.md
# Per-Lane Variable Vector Shifter

This block shifts every lane of a 128-bit vector operand by an amount carried in the matching lane of a second 128-bit vector. The lane size is selectable at 8, 16, 32 or 64 bits. Each lane reads its shift amount as a signed byte. A positive or zero amount shifts left. A negative amount shifts right by its magnitude, and that right shift either copies the sign bit or fills with zeros. Any magnitude that reaches the lane width clears the lane.

A narrow mode processes only the low 64 bits and clears the upper half of the result. The operands are captured on an input strobe. The result and its valid flag appear one clock later and hold until the next strobe.

Top module: `vec_lane_shifter`

## Requirements
- R1: The lane width is 8 << laneSize, so codes 0, 1, 2 and 3 give lanes of 8, 16, 32 and 64 bits. Lane i occupies bits [i*W +: W] of opA, opB and result, and each lane is computed independently of the others.
- R2: The shift amount of a lane is bits [i*W +: 8] of opB, read as a two's-complement value. All other bits of that opB lane have no effect on the result.
- R3: An amount from 0 to W-1 shifts the opA lane left and fills with zeros. Bits pushed past the lane's top bit are lost.
- R4: A negative amount whose magnitude is below W shifts the lane right by that magnitude. The vacated bits take the lane's top bit when signedMode is 1 and zero when signedMode is 0.
- R5: A lane result is zero whenever the magnitude of its amount is W or more, in both directions and both modes. This includes an amount of -128, which has a magnitude of 128.
- R6: When fullWidth is 0, result[63:0] is computed as usual and result[127:64] is zero.
- R7: outValid is 1 in the cycle after a clock edge that sampled inValid=1, and 0 in the cycle after one that sampled inValid=0. result takes the new value together with outValid and otherwise keeps its value.
- R8: A synchronous active-high rst sets outValid to 0 and result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operands valid; capture on this edge |
| opA | input | 128 | Data vector to be shifted |
| opB | input | 128 | Vector of per-lane shift amounts |
| laneSize | input | 2 | Lane size code; width is 8 << code |
| signedMode | input | 1 | 1 = arithmetic right shift, 0 = logical |
| fullWidth | input | 1 | 1 = all 128 bits, 0 = low 64 bits only |
| outValid | output | 1 | Result valid, one cycle after inValid |
| result | output | 128 | Shifted vector |

## Verification
Within a single operation, some lanes shift left, some shift right and some hit the zeroing limit, all in the same cycle. The sweep makes this happen on purpose. It gives each lane of one vector a different amount, spread across negative, positive and out-of-range values, with random bits above the amount byte. Every lane of the registered result is then compared with an arithmetic model evaluated separately for that lane. The same sweep runs with the narrow mode on, so lane-local zeroing and clearing of the upper half also coincide in one cycle. A mid-run reset is raised while an operand strobe is active, to check that clearing wins over capture.

// File: rtl/vshift_pkg.sv
package vshift_pkg;
  localparam int VecW = 128;
  localparam int AmtW = 8;
  localparam int NumSizes = 4;

  typedef struct packed {
    logic load;
    logic clear;
  } vsStrobe_t;
endpackage

// File: rtl/vshift_lane.sv
module vshift_lane #(
  parameter int LANE_W = 8,
  parameter int AMT_W = 8
) (
  input  logic [LANE_W-1:0] laneA,
  input  logic [AMT_W-1:0]  amtByte,
  input  logic              arith,
  output logic [LANE_W-1:0] laneOut
);
  localparam int ShW = $clog2(LANE_W);
  localparam int MagW = AMT_W + 1;

  logic            isNeg;
  logic [MagW-1:0] amtExt;
  logic [MagW-1:0] mag;
  logic            tooFar;
  logic [ShW-1:0]  shAmt;
  logic            fillBit;
  logic [LANE_W:0] rightExt;
  logic [LANE_W-1:0] leftRes;

  always_comb begin
    isNeg   = amtByte[AMT_W-1];
    amtExt  = {amtByte[AMT_W-1], amtByte};
    mag     = isNeg ? (MagW'(0) - amtExt) : amtExt;
    tooFar  = (mag >= MagW'(LANE_W));
    shAmt   = mag[ShW-1:0];
    fillBit = arith & laneA[LANE_W-1];
    rightExt = {fillBit, laneA};
    rightExt = $unsigned($signed(rightExt) >>> shAmt);
    leftRes  = laneA << shAmt;
    if (tooFar)
      laneOut = '0;
    else if (isNeg)
      laneOut = rightExt[LANE_W-1:0];
    else
      laneOut = leftRes;
  end
endmodule

// File: rtl/vshift_ctrl.sv
module vshift_ctrl
  import vshift_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  output vsStrobe_t strobes,
  output logic      outValid
);
  always_comb begin
    strobes.clear = rst;
    strobes.load  = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst)
      outValid <= 1'b0;
    else
      outValid <= inValid;
  end
endmodule

// File: rtl/vshift_datapath.sv
module vshift_datapath
  import vshift_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int AMT_W = 8
) (
  input  logic             clk,
  input  vsStrobe_t        strobes,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  input  logic [1:0]       laneSize,
  input  logic             signedMode,
  input  logic             fullWidth,
  output logic [VEC_W-1:0] result
);
  localparam int HalfW = VEC_W / 2;
  localparam int BaseW = 8;

  logic [VEC_W-1:0] resBySize [NumSizes];
  logic [VEC_W-1:0] picked;
  logic [VEC_W-1:0] nextRes;

  for (genvar s = 0; s < NumSizes; s++) begin : g_size
    localparam int LaneW = BaseW << s;
    localparam int NumLanes = VEC_W / LaneW;
    for (genvar j = 0; j < NumLanes; j++) begin : g_lane
      vshift_lane #(
        .LANE_W(LaneW),
        .AMT_W (AMT_W)
      ) u_lane (
        .laneA  (opA[j*LaneW +: LaneW]),
        .amtByte(opB[j*LaneW +: AMT_W]),
        .arith  (signedMode),
        .laneOut(resBySize[s][j*LaneW +: LaneW])
      );
    end
  end

  always_comb begin
    picked  = resBySize[laneSize];
    nextRes = picked;
    if (!fullWidth)
      nextRes[VEC_W-1:HalfW] = '0;
  end

  always_ff @(posedge clk) begin
    if (strobes.clear)
      result <= '0;
    else if (strobes.load)
      result <= nextRes;
  end
endmodule

// File: rtl/vec_lane_shifter.sv
module vec_lane_shifter
  import vshift_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  logic [VecW-1:0] opA,
  input  logic [VecW-1:0] opB,
  input  logic [1:0]      laneSize,
  input  logic            signedMode,
  input  logic            fullWidth,
  output logic            outValid,
  output logic [VecW-1:0] result
);
  vsStrobe_t strobes;

  vshift_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  vshift_datapath #(
    .VEC_W(VecW),
    .AMT_W(AmtW)
  ) u_dp (
    .clk       (clk),
    .strobes   (strobes),
    .opA       (opA),
    .opB       (opB),
    .laneSize  (laneSize),
    .signedMode(signedMode),
    .fullWidth (fullWidth),
    .result    (result)
  );
endmodule

// File: rtl/vshift_chk.sv
module vshift_chk
  import vshift_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            inValid,
  input logic [VecW-1:0] opA,
  input logic [VecW-1:0] opB,
  input logic [1:0]      laneSize,
  input logic            signedMode,
  input logic            fullWidth,
  input logic            outValid,
  input logic [VecW-1:0] result
);
  logic prevRst;

  // R7
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R7
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(result));

  // R6
  upper_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && !fullWidth) |=> (result[VecW-1:VecW/2] == '0));

  // R5
  min_amount_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && opB == {(VecW/8){8'h80}}) |=> (result == '0));

  always_ff @(posedge clk) begin
    prevRst <= rst;
    // R8
    if (prevRst === 1'b1)
      reset_clear_chk: assert (!outValid && result == '0);
  end
endmodule

bind vec_lane_shifter vshift_chk u_chk (.*);

// File: tb/tb_vec_lane_shifter.sv
module tb_vec_lane_shifter;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [127:0] opA = '0;
  logic [127:0] opB = '0;
  logic [1:0]   laneSize = 2'd0;
  logic         signedMode = 1'b0;
  logic         fullWidth = 1'b1;
  logic         outValid;
  logic [127:0] result;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  vec_lane_shifter dut (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .laneSize(laneSize), .signedMode(signedMode), .fullWidth(fullWidth),
    .outValid(outValid), .result(result)
  );

  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input int sz, input logic sgn, input logic full);
    logic [127:0] res = '0;
    int lw = 8 << sz;
    int nl = 128 / lw;
    logic [127:0] mask = (128'd1 << lw) - 128'd1;
    for (int i = 0; i < nl; i++) begin
      logic [127:0] la = (a >> (i * lw)) & mask;
      logic [7:0] ab = 8'((b >> (i * lw)) & 128'hFF);
      int amt = ab[7] ? int'(ab) - 256 : int'(ab);
      int mag = amt < 0 ? -amt : amt;
      logic [127:0] r;
      if (!full && i >= nl / 2) r = '0;
      else if (mag >= lw) r = '0;
      else if (amt >= 0) r = (la * (128'd1 << mag)) & mask;
      else begin
        r = la / (128'd1 << mag);
        if (sgn && la[lw-1]) r = r | (mask & ~(mask >> mag));
      end
      res = res | (r << (i * lw));
    end
    return res;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doOp(input string tag, input logic [127:0] a, input logic [127:0] b,
                      input int sz, input logic sgn, input logic full);
    @(negedge clk);
    opA = a; opB = b; laneSize = 2'(sz); signedMode = sgn; fullWidth = full;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    opA = ~a; opB = ~b;
    check({tag, " valid R7"}, 128'(outValid), 128'd1);
    check(tag, result, model(a, b, sz, sgn, full));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] held;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 reset valid", 128'(outValid), 128'd0);
    check("R8 reset result", result, 128'd0);
    rst = 1'b0;

    // Directed cases on 8-bit lanes, lane 0
    doOp("R3 left drop", 128'hFF, 128'h04, 0, 1'b0, 1'b1);
    check("R3 left drop const", result, 128'hF0);
    doOp("R4 arith right", 128'h80, 128'hFF, 0, 1'b1, 1'b1);
    check("R4 arith const", result, 128'hC0);
    doOp("R4 logical right", 128'h80, 128'hFF, 0, 1'b0, 1'b1);
    check("R4 logical const", result, 128'h40);
    doOp("R5 amount 8", 128'hFF, 128'h08, 0, 1'b0, 1'b1);
    check("R5 amount 8 const", result, 128'h00);
    doOp("R5 amount -8", 128'h80, 128'hF8, 0, 1'b1, 1'b1);
    check("R5 amount -8 const", result, 128'h00);
    doOp("R3 amount 7", 128'h01, 128'h07, 0, 1'b0, 1'b1);
    check("R3 amount 7 const", result, 128'h80);
    doOp("R5 minus 128", {4{32'hDEADBEEF}}, {16{8'h80}}, 3, 1'b1, 1'b1);
    check("R5 minus 128 const", result, 128'd0);
    // R2: junk above the amount byte of a 16-bit lane
    doOp("R2 junk bits", 128'h0001, 128'hAB01, 1, 1'b0, 1'b1);
    check("R2 junk const", result, 128'h0002);

    // R7 hold: idle cycles keep result and drop valid
    held = result;
    repeat (3) begin
      @(negedge clk);
      check("R7 idle valid", 128'(outValid), 128'd0);
      check("R7 hold result", result, held);
    end

    // Sweep: every size, mode and width; per-lane varied amounts
    for (int sz = 0; sz < 4; sz++)
      for (int sg = 0; sg < 2; sg++)
        for (int fw = 0; fw < 2; fw++)
          for (int k = 0; k < 256; k++) begin
            logic [127:0] a;
            logic [127:0] b;
            int lw = 8 << sz;
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            for (int i = 0; i < 128 / lw; i++)
              b[i*lw +: 8] = 8'(k + i * 37);
            doOp(fw ? "R1 R2 R3 R4 R5 sweep" : "R6 narrow sweep", a, b, sz, 1'(sg), 1'(fw));
          end

    // R8 mid-run reset with a strobe active
    @(negedge clk);
    opA = '1; opB = '0; laneSize = 2'd0; fullWidth = 1'b1;
    inValid = 1'b1; rst = 1'b1;
    @(negedge clk);
    inValid = 1'b0; rst = 1'b0;
    check("R8 mid reset valid", 128'(outValid), 128'd0);
    check("R8 mid reset result", result, 128'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule